// File: doc/BRIEF.md
# Multi-Select Bus-Attached Static RAM

This block is a 128-word by 8-bit static memory meant to hang directly on a shared, bidirectional 8-bit processor data bus. The bus is split into an input byte, an output byte and an output-enable, so that a pad ring or bus fabric above it can build the real tri-state line. The block responds only when all five of its select lines sit at their own fixed active levels. Two of the selects are active high and three are active low, which lets several of these memories share one address decode.

Two active-low strobes, one for read and one for write, choose what the block does when it is selected. A read drives the addressed word onto the bus. A write stores the bus byte. With both strobes high the block is in standby and holds its contents. If both strobes are low at once, that is a protocol violation: the block does nothing to memory, leaves the bus alone and raises a sticky error flag.

The model is synchronous. Every condition is sampled on the rising clock edge, and read data with its enable appear one clock after the read is sampled.

Top module: `bus_sram`

## Requirements
- R1: The block is selected only when the select vector `sel` equals 5'b01001, with bits 0 and 3 active high and bits 1, 2 and 4 active low. Any other select value leaves `bus_oe` low on the next cycle and makes both strobes have no effect on memory.
- R2: When selected, with `rd_n`=0 and `wr_n`=1 sampled on an edge, `bus_oe` is 1 after that edge and `bus_out` carries the word stored at `addr`.
- R3: When selected, with `wr_n`=0 and `rd_n`=1 sampled on an edge, `bus_in` is stored at `addr` on that edge and `bus_oe` is 0 after it.
- R4: When selected with both strobes high (standby), `bus_oe` is 0 on the next cycle and no word changes.
- R5: While a read is held, the output tracks the address: one cycle after `addr` changes, `bus_out` shows the new word.
- R6: When selected with both strobes low, nothing is written, `bus_oe` is 0 on the next cycle and `proto_err` becomes 1. Both strobes low while deselected does not set `proto_err`.
- R7: While `rst_n` is low, `bus_oe`, `bus_out` and `proto_err` are all 0. Reset does not initialise the memory contents.
- R8: `bus_out` is all zeros whenever `bus_oe` is 0.
- R9: Once set, `proto_err` stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 5 | Select lines, each with its own active level |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 7 | Word address |
| bus_in | input | 8 | Byte received from the shared bus |
| bus_out | output | 8 | Byte to drive onto the shared bus |
| bus_oe | output | 1 | Drive enable for the shared bus |
| proto_err | output | 1 | Sticky flag for both strobes low while selected |

## Verification
The embedded assertions check the following on every cycle:
- the bus is enabled only after a sampled read;
- a deselected, standby, write or clashing cycle leaves the bus undriven;
- the error flag rises after a clash and never falls outside reset.

Whether the right byte arrives can only be shown by the bench's scenarios. These cover the word stored by an earlier write, a write blocked by one wrong select or by a strobe clash, standby leaving contents intact, and the output following an address change during a held read. The bench shows these against its own shadow copy of the memory.

// File: rtl/bus_sram_pkg.sv
package bus_sram_pkg;
   typedef enum logic [2:0] {
      MODE_OFF,
      MODE_IDLE,
      MODE_READ,
      MODE_WRITE,
      MODE_CLASH
   } sram_mode_e;
endpackage

// File: rtl/bus_sram_decode.sv
module bus_sram_decode
   import bus_sram_pkg::*;
#(
   parameter int          NSEL       = 5,
   parameter logic [NSEL-1:0] SEL_ACTIVE = 5'b01001
) (
   input  logic [NSEL-1:0] sel,
   input  logic            rd_n,
   input  logic            wr_n,
   output logic            sel_ok,
   output sram_mode_e      mode
);
   logic [NSEL-1:0] hit;

   for (genvar i = 0; i < NSEL; i++) begin : g_sel
      if (SEL_ACTIVE[i]) begin : g_high
         assign hit[i] = sel[i];
      end else begin : g_low
         assign hit[i] = ~sel[i];
      end
   end

   assign sel_ok = &hit;

   always_comb begin
      if (!sel_ok)              mode = MODE_OFF;
      else if (!rd_n && !wr_n)  mode = MODE_CLASH;
      else if (!rd_n)           mode = MODE_READ;
      else if (!wr_n)           mode = MODE_WRITE;
      else                      mode = MODE_IDLE;
   end
endmodule

// File: rtl/bus_sram_array.sv
module bus_sram_array #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 7,
   parameter int WORDS  = 128
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] mem [WORDS];

   initial begin
      if (WORDS > (1 << ADDR_W)) $error("bus_sram_array: WORDS exceeds address range");
   end

   always_ff @(posedge clk) begin
      if (we) mem[addr] <= wdata;
   end

   assign rdata = mem[addr];
endmodule

// File: rtl/bus_sram_rdport.sv
module bus_sram_rdport #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic [DATA_W-1:0] rdata,
   output logic              oe,
   output logic [DATA_W-1:0] dout
);
   logic              oe_q;
   logic [DATA_W-1:0] d_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         oe_q <= 1'b0;
         d_q  <= '0;
      end else begin
         oe_q <= rd_en;
         if (rd_en) d_q <= rdata;
      end
   end

   assign oe   = oe_q;
   assign dout = oe_q ? d_q : '0;

   p_quiet_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !oe |-> (dout == '0));
endmodule

// File: rtl/bus_sram.sv
module bus_sram
   import bus_sram_pkg::*;
#(
   parameter int              NSEL       = 5,
   parameter logic [NSEL-1:0] SEL_ACTIVE = 5'b01001,
   parameter int              DATA_W     = 8,
   parameter int              ADDR_W     = 7,
   parameter int              WORDS      = 128
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSEL-1:0]   sel,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] bus_in,
   output logic [DATA_W-1:0] bus_out,
   output logic              bus_oe,
   output logic              proto_err
);
   localparam int MIN_WORDS = 2;

   initial begin
      if (WORDS < MIN_WORDS) $error("bus_sram: WORDS too small");
      if (NSEL < 1)          $error("bus_sram: need at least one select");
   end

   logic              sel_ok;
   sram_mode_e        mode;
   logic [DATA_W-1:0] rdata;
   logic              err_q;

   bus_sram_decode #(.NSEL(NSEL), .SEL_ACTIVE(SEL_ACTIVE)) u_dec (
      .sel(sel), .rd_n(rd_n), .wr_n(wr_n), .sel_ok(sel_ok), .mode(mode)
   );

   bus_sram_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .WORDS(WORDS)) u_mem (
      .clk(clk), .we(mode == MODE_WRITE), .addr(addr),
      .wdata(bus_in), .rdata(rdata)
   );

   bus_sram_rdport #(.DATA_W(DATA_W)) u_rd (
      .clk(clk), .rst_n(rst_n), .rd_en(mode == MODE_READ),
      .rdata(rdata), .oe(bus_oe), .dout(bus_out)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  err_q <= 1'b0;
      else if (mode == MODE_CLASH) err_q <= 1'b1;
   end

   assign proto_err = err_q;

   p_oe_after_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_oe |-> $past(sel_ok && !rd_n && wr_n));
   p_off_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_ok |=> !bus_oe);
   p_write_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_ok && !wr_n && rd_n) |=> !bus_oe);
   p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_ok && rd_n && wr_n) |=> !bus_oe);
   p_clash_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_ok && !rd_n && !wr_n) |=> (proto_err && !bus_oe));
   p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(proto_err) |-> proto_err);
endmodule

// File: tb/bus_sram_test.sv
module bus_sram_test;
   localparam logic [4:0] SEL_ON = 5'b01001;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] sel = 5'b10110;
   logic       rd_n = 1'b1, wr_n = 1'b1;
   logic [6:0] addr = '0;
   logic [7:0] bus_in = '0;
   logic [7:0] bus_out;
   logic       bus_oe, proto_err;

   always #2.5 clk = ~clk;

   bus_sram uut (
      .clk(clk), .rst_n(rst_n), .sel(sel), .rd_n(rd_n), .wr_n(wr_n),
      .addr(addr), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
      .proto_err(proto_err)
   );

   typedef struct {
      logic       oe;
      logic [7:0] d;
      logic       err;
      string      req;
   } exp_t;

   exp_t       q[$];
   logic [7:0] shadow [128];
   logic       err_m = 1'b0;
   int         n_chk = 0, n_fail = 0;

   task automatic chk(input logic ok, input string req, input string what,
                      input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
      end
   endtask

   task automatic op(input logic [4:0] s, input logic r, input logic w,
                     input logic [6:0] a, input logic [7:0] d, input string req);
      exp_t e;
      logic on;
      @(negedge clk);
      sel = s; rd_n = r; wr_n = w; addr = a; bus_in = d;
      on = (s == SEL_ON);
      e.oe = on && !r && w;
      e.d  = e.oe ? shadow[a] : 8'h00;
      if (on && !w && r) shadow[a] = d;
      if (on && !w && !r) err_m = 1'b1;
      e.err = err_m;
      e.req = req;
      q.push_back(e);
   endtask

   always @(posedge clk) begin
      #1;
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         chk(bus_oe == e.oe, e.req, "bus_oe", int'(bus_oe), int'(e.oe));
         chk(bus_out == e.d, e.req, "bus_out", int'(bus_out), int'(e.d));
         chk(proto_err == e.err, e.req, "proto_err", int'(proto_err), int'(e.err));
      end
   end

   task automatic drain();
      op(5'b10110, 1'b1, 1'b1, 7'd0, 8'h00, "R1");
      wait (q.size() == 0);
   endtask

   task automatic check_reset();
      @(posedge clk); #1;
      chk(bus_oe == 1'b0, "R7", "reset bus_oe", int'(bus_oe), 0);
      chk(bus_out == 8'h00, "R7", "reset bus_out", int'(bus_out), 0);
      chk(proto_err == 1'b0, "R7", "reset proto_err", int'(proto_err), 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      check_reset();
      @(negedge clk) rst_n = 1'b1;

      // R3 / R2: store then fetch, including both address extremes
      op(SEL_ON, 1'b1, 1'b0, 7'd0,   8'hA5, "R3");
      op(SEL_ON, 1'b1, 1'b0, 7'd127, 8'h5A, "R3");
      op(SEL_ON, 1'b1, 1'b0, 7'd5,   8'h3C, "R3");
      op(SEL_ON, 1'b1, 1'b0, 7'd64,  8'hFF, "R3");
      op(SEL_ON, 1'b0, 1'b1, 7'd0,   8'h00, "R2");
      op(SEL_ON, 1'b0, 1'b1, 7'd127, 8'h00, "R2");
      op(SEL_ON, 1'b0, 1'b1, 7'd64,  8'h00, "R2");
      // R5: held read, then address change during the read
      op(SEL_ON, 1'b0, 1'b1, 7'd5,   8'h00, "R5");
      op(SEL_ON, 1'b0, 1'b1, 7'd5,   8'h00, "R5");
      op(SEL_ON, 1'b0, 1'b1, 7'd127, 8'h00, "R5");
      op(SEL_ON, 1'b0, 1'b1, 7'd0,   8'h00, "R5");
      // R1: each select at its wrong level, for both read and write
      for (int i = 0; i < 5; i++) begin
         op(SEL_ON ^ (5'b1 << i), 1'b0, 1'b1, 7'd5, 8'h00, "R1");
         op(SEL_ON ^ (5'b1 << i), 1'b1, 1'b0, 7'd5, 8'h11 + 8'(i), "R1");
         op(SEL_ON, 1'b0, 1'b1, 7'd5, 8'h00, "R1");
      end
      // R4: standby with changing bus data, contents kept
      op(SEL_ON, 1'b1, 1'b1, 7'd64, 8'h00, "R4");
      op(SEL_ON, 1'b1, 1'b1, 7'd0,  8'h77, "R4");
      op(SEL_ON, 1'b0, 1'b1, 7'd64, 8'h00, "R4");
      op(SEL_ON, 1'b0, 1'b1, 7'd0,  8'h00, "R4");
      // R6: clash while deselected must not flag
      op(5'b01000, 1'b0, 1'b0, 7'd0, 8'h99, "R6");
      // R6: clash while selected flags, writes nothing, drives nothing
      op(SEL_ON, 1'b0, 1'b0, 7'd0, 8'h99, "R6");
      op(SEL_ON, 1'b0, 1'b1, 7'd0, 8'h00, "R6");
      // R9: flag survives later normal traffic
      op(SEL_ON, 1'b1, 1'b0, 7'd9, 8'h42, "R9");
      op(SEL_ON, 1'b1, 1'b1, 7'd9, 8'h00, "R9");
      op(SEL_ON, 1'b0, 1'b1, 7'd9, 8'h00, "R9");
      op(SEL_ON, 1'b1, 1'b1, 7'd9, 8'h00, "R8");
      drain();

      // R7: reset clears flag and enable; stored words survive
      @(negedge clk) rst_n = 1'b0;
      err_m = 1'b0;
      check_reset();
      @(negedge clk) rst_n = 1'b1;
      op(SEL_ON, 1'b0, 1'b1, 7'd9, 8'h00, "R7");
      op(SEL_ON, 1'b0, 1'b1, 7'd127, 8'h00, "R7");
      drain();

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule